// File: doc/BRIEF.md
# Camera Sensor Register Configuration Master

This block drives the two-wire serial control bus of a CMOS image sensor. The bus is I2C-compatible. Once reset is released, the block works through a fixed table of register/value pairs held inside it. Each pair goes to the sensor as a single bus write. The table sets the sensor's pixel output to 16-bit RGB with a 5/6/5 split. One table code stands for "pause about ten milliseconds", which gives the sensor time to recover after its soft reset. Another code ends the table. When the end code is reached, a configuration-done flag rises, and the pixel capture logic may start once it sees that flag.

With configuration complete, a host can ask for one register write or one register read at a time. A write takes a single bus transaction. A read takes two: a write phase that sets the register pointer, then a read phase that returns one byte, which the block presents with a one-cycle valid strobe. A busy output stays high for the whole of any bus activity. A request is taken only in a cycle where the block is idle and configuration is done; a request raised at any other time is dropped. The bus clock comes from the system clock through a parameterised divider. Each bit is cut into four equal quarter-periods, so the data line only moves while the clock line is low, except at start and stop conditions.

Top module: `cam_cfg_master`

## Requirements
- R1: While reset is held, `scl` is 1, `sdaLow` is 0, `cfgDone` is 0, `busy` is 1 and `rdValid` is 0.
- R2: After reset the block issues these register writes, in this order, as (register, value): (0x12,0x80), (0x12,0x04), (0x40,0xD0), (0x8C,0x00), (0x3A,0x04), (0x11,0x01). These come from a table whose code 0xF0 means pause and whose code 0xFF means end. The 0x12/0x04 and 0x40/0xD0 writes select RGB 5/6/5 output.
- R3: The pause entry falls between the first and second write. The bus stays idle for at least `DELAY_CYCLES` clock cycles from the stop of the first write to the start of the second. Consecutive writes that have no pause between them are separated by fewer than `DELAY_CYCLES` cycles.
- R4: A host write, and every table write, is sent as: a start condition, the byte 0x42, the register byte, the data byte, then a stop condition. Bytes go out MSB first. On the ninth clock of each byte the master releases SDA.
- R5: A host read is sent as: start, 0x42, register byte, stop, then start, 0x43, eight data bits driven by the sensor and sampled MSB first, a ninth clock with SDA left high by the master (no acknowledge), and stop. The byte read appears on `rdData`.
- R6: SDA moves while SCL is high only at start and stop conditions. A write therefore contains exactly one start and one stop, and a read exactly two of each.
- R7: Every high phase of SCL inside a byte lasts CLK_HZ/(2·SCL_HZ) clock cycles.
- R8: `cfgDone` stays 0 until the stop of the last table write and then stays 1 until reset. Throughout configuration, `busy` is 1.
- R9: `busy` is 1 during every transaction. SCL is low only while `busy` is 1. Whenever `busy` is 0, SCL is high and SDA is released.
- R10: A request (`reqValid`) raised while `busy` is 1 or `cfgDone` is 0 is ignored and puts no transaction on the bus.
- R11: `rdValid` is a single-cycle pulse. It fires exactly once at the end of each host read and never after a write, and it coincides with `busy` falling to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Host request strobe |
| reqWrite | input | 1 | 1 = register write, 0 = register read |
| reqAddr | input | 8 | Sensor register address |
| reqData | input | 8 | Data for a write request |
| rdValid | output | 1 | One-cycle strobe when read data is available |
| rdData | output | 8 | Byte returned by the last read |
| busy | output | 1 | High while configuring or during a transaction |
| cfgDone | output | 1 | High once the startup table has been fully written |
| scl | output | 1 | Serial clock line |
| sdaLow | output | 1 | 1 pulls the data line low, 0 releases it |
| sdaIn | input | 1 | Sensed level of the data line |

## Verification
The hardest thing to reach from the ports is a request that arrives while the block cannot accept it. This has to happen once during the startup table and once in the cycle right after an accepted request, and in both cases the bus must show no extra transaction. The bench forces both: it raises a request a few cycles after reset, and it raises a second request immediately after a host write has been taken. A bus-level sensor model in the bench logs every write. It also serves reads from a register array preset with an arithmetic pattern, which allows all 256 register addresses to be read back and compared.

// File: rtl/cam_cfg_pkg.sv
package cam_cfg_pkg;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } busOp_e;

  // Strobe bundle from the sequencer to the bit engine.
  typedef struct packed {
    logic   go;
    busOp_e kind;
    logic [7:0] data;
  } busCmd_t;

  localparam logic [7:0] DEV_WR   = 8'h42;
  localparam logic [7:0] DEV_RD   = 8'h43;
  localparam logic [7:0] TAG_END  = 8'hFF;
  localparam logic [7:0] TAG_WAIT = 8'hF0;

  localparam int TBL_LEN = 8;
  localparam int TBL_W   = $clog2(TBL_LEN);

  localparam logic [2:0] LAST_WR_STEP = 3'd4;
  localparam logic [2:0] LAST_RD_STEP = 3'd7;

  // Startup entries as {register, value}.
  function automatic logic [15:0] initEntry(input logic [TBL_W-1:0] idx);
    case (idx)
      3'd0:    return 16'h1280;  // sensor soft reset
      3'd1:    return 16'hF000;  // settle pause
      3'd2:    return 16'h1204;  // RGB output
      3'd3:    return 16'h40D0;  // 5/6/5 packing, full range
      3'd4:    return 16'h8C00;  // 4/4/4 packing off
      3'd5:    return 16'h3A04;  // line buffer ordering
      3'd6:    return 16'h1101;  // clock prescale
      default: return 16'hFFFF;  // end of table
    endcase
  endfunction

  // Operation issued at a given step of a write or read transaction.
  function automatic busCmd_t stepCmd(input logic rd, input logic [2:0] st,
                                      input logic [7:0] a, input logic [7:0] d);
    busCmd_t c;
    c.go   = 1'b0;
    c.kind = OP_STOP;
    c.data = 8'h00;
    if (!rd) begin
      case (st)
        3'd0: c.kind = OP_START;
        3'd1: begin c.kind = OP_WRITE; c.data = DEV_WR; end
        3'd2: begin c.kind = OP_WRITE; c.data = a; end
        3'd3: begin c.kind = OP_WRITE; c.data = d; end
        default: c.kind = OP_STOP;
      endcase
    end else begin
      case (st)
        3'd0: c.kind = OP_START;
        3'd1: begin c.kind = OP_WRITE; c.data = DEV_WR; end
        3'd2: begin c.kind = OP_WRITE; c.data = a; end
        3'd3: c.kind = OP_STOP;
        3'd4: c.kind = OP_START;
        3'd5: begin c.kind = OP_WRITE; c.data = DEV_RD; end
        3'd6: c.kind = OP_READ;
        default: c.kind = OP_STOP;
      endcase
    end
    return c;
  endfunction

endpackage

// File: rtl/cam_cfg_bus.sv
module cam_cfg_bus
  import cam_cfg_pkg::*;
#(
  parameter int QUARTER = 250
) (
  input  logic       clk,
  input  logic       rst,
  input  busCmd_t    cmd,
  input  logic       sdaIn,
  output logic       opDone,
  output logic [7:0] rdByte,
  output logic       scl,
  output logic       sdaLow
);

  localparam int CW = (QUARTER > 1) ? $clog2(QUARTER) : 1;

  logic          active;
  busOp_e        kind;
  logic [1:0]    q;
  logic [CW-1:0] cnt;
  logic [3:0]    bitIdx;
  logic [7:0]    shiftOut;
  logic [7:0]    shiftIn;

  logic quarterEnd;
  logic byteOp;
  logic sclNext;
  logic lowNext;

  assign quarterEnd = (cnt == CW'(QUARTER - 1));
  assign byteOp     = (kind == OP_WRITE) || (kind == OP_READ);

  // Line levels for the current quarter of the current operation.
  always_comb begin
    sclNext = 1'b1;
    lowNext = 1'b0;
    case (kind)
      OP_START: begin
        sclNext = (q == 2'd0) || (q == 2'd1);
        lowNext = (q != 2'd0);
      end
      OP_STOP: begin
        sclNext = (q != 2'd0);
        lowNext = (q == 2'd0) || (q == 2'd1);
      end
      OP_WRITE: begin
        sclNext = (q == 2'd1) || (q == 2'd2);
        lowNext = (bitIdx < 4'd8) && !shiftOut[7];
      end
      default: begin
        sclNext = (q == 2'd1) || (q == 2'd2);
        lowNext = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      kind     <= OP_START;
      q        <= 2'd0;
      cnt      <= '0;
      bitIdx   <= 4'd0;
      shiftOut <= 8'h00;
      shiftIn  <= 8'h00;
      opDone   <= 1'b0;
      rdByte   <= 8'h00;
      scl      <= 1'b1;
      sdaLow   <= 1'b0;
    end else begin
      opDone <= 1'b0;
      if (!active) begin
        if (cmd.go) begin
          active   <= 1'b1;
          kind     <= cmd.kind;
          q        <= 2'd0;
          cnt      <= '0;
          bitIdx   <= 4'd0;
          shiftOut <= cmd.data;
        end
      end else begin
        scl    <= sclNext;
        sdaLow <= lowNext;
        if (kind == OP_READ && q == 2'd2 && cnt == '0 && bitIdx < 4'd8)
          shiftIn <= {shiftIn[6:0], sdaIn};
        if (quarterEnd) begin
          cnt <= '0;
          q   <= q + 2'd1;
          if (q == 2'd3) begin
            if (byteOp && bitIdx != 4'd8) begin
              bitIdx   <= bitIdx + 4'd1;
              shiftOut <= {shiftOut[6:0], 1'b0};
            end else begin
              active <= 1'b0;
              opDone <= 1'b1;
              if (kind == OP_READ) rdByte <= shiftIn;
            end
          end
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/cam_cfg_seq.sv
module cam_cfg_seq
  import cam_cfg_pkg::*;
#(
  parameter int DELAY_CYCLES = 1_000_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic [7:0] reqAddr,
  input  logic [7:0] reqData,
  input  logic       opDone,
  input  logic [7:0] rdByte,
  output busCmd_t    cmd,
  output logic       cfgDone,
  output logic       busy,
  output logic       rdValid,
  output logic [7:0] rdData
);

  localparam int DW = $clog2(DELAY_CYCLES + 1);

  typedef enum logic [2:0] {
    S_FETCH, S_PAUSE, S_ISSUE, S_WAIT, S_IDLE
  } seqState_e;

  seqState_e        state;
  logic [TBL_W-1:0] tblIdx;
  logic [DW-1:0]    pauseCnt;
  logic [7:0]       curAddr;
  logic [7:0]       curData;
  logic             isRead;
  logic [2:0]       step;
  logic [2:0]       lastStep;
  logic [15:0]      entry;

  assign lastStep = isRead ? LAST_RD_STEP : LAST_WR_STEP;
  assign busy     = (state != S_IDLE);

  always_comb begin
    entry  = initEntry(tblIdx);
    cmd    = stepCmd(isRead, step, curAddr, curData);
    cmd.go = (state == S_ISSUE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_FETCH;
      tblIdx   <= '0;
      pauseCnt <= '0;
      curAddr  <= 8'h00;
      curData  <= 8'h00;
      isRead   <= 1'b0;
      step     <= 3'd0;
      cfgDone  <= 1'b0;
      rdValid  <= 1'b0;
      rdData   <= 8'h00;
    end else begin
      rdValid <= 1'b0;
      case (state)
        S_FETCH: begin
          if (entry[15:8] == TAG_END) begin
            cfgDone <= 1'b1;
            state   <= S_IDLE;
          end else if (entry[15:8] == TAG_WAIT) begin
            pauseCnt <= '0;
            state    <= S_PAUSE;
          end else begin
            curAddr <= entry[15:8];
            curData <= entry[7:0];
            isRead  <= 1'b0;
            step    <= 3'd0;
            state   <= S_ISSUE;
          end
        end
        S_PAUSE: begin
          if (pauseCnt == DW'(DELAY_CYCLES - 1)) begin
            tblIdx <= tblIdx + 1'b1;
            state  <= S_FETCH;
          end else begin
            pauseCnt <= pauseCnt + 1'b1;
          end
        end
        S_ISSUE: state <= S_WAIT;
        S_WAIT: begin
          if (opDone) begin
            if (step == lastStep) begin
              if (!cfgDone) begin
                tblIdx <= tblIdx + 1'b1;
                state  <= S_FETCH;
              end else begin
                state <= S_IDLE;
                if (isRead) begin
                  rdValid <= 1'b1;
                  rdData  <= rdByte;
                end
              end
            end else begin
              step  <= step + 3'd1;
              state <= S_ISSUE;
            end
          end
        end
        S_IDLE: begin
          if (reqValid) begin
            curAddr <= reqAddr;
            curData <= reqData;
            isRead  <= !reqWrite;
            step    <= 3'd0;
            state   <= S_ISSUE;
          end
        end
        default: state <= S_FETCH;
      endcase
    end
  end

endmodule

// File: rtl/cam_cfg_master.sv
module cam_cfg_master
  import cam_cfg_pkg::*;
#(
  parameter int CLK_HZ       = 100_000_000,
  parameter int SCL_HZ       = 100_000,
  parameter int DELAY_CYCLES = CLK_HZ / 100
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic [7:0] reqAddr,
  input  logic [7:0] reqData,
  output logic       rdValid,
  output logic [7:0] rdData,
  output logic       busy,
  output logic       cfgDone,
  output logic       scl,
  output logic       sdaLow,
  input  logic       sdaIn
);

  localparam int QUARTER_RAW = CLK_HZ / (4 * SCL_HZ);
  localparam int QUARTER     = (QUARTER_RAW < 1) ? 1 : QUARTER_RAW;

  busCmd_t    cmd;
  logic       opDone;
  logic [7:0] rdByte;

  cam_cfg_seq #(.DELAY_CYCLES(DELAY_CYCLES)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .reqData  (reqData),
    .opDone   (opDone),
    .rdByte   (rdByte),
    .cmd      (cmd),
    .cfgDone  (cfgDone),
    .busy     (busy),
    .rdValid  (rdValid),
    .rdData   (rdData)
  );

  cam_cfg_bus #(.QUARTER(QUARTER)) u_bus (
    .clk    (clk),
    .rst    (rst),
    .cmd    (cmd),
    .sdaIn  (sdaIn),
    .opDone (opDone),
    .rdByte (rdByte),
    .scl    (scl),
    .sdaLow (sdaLow)
  );

endmodule

// File: rtl/cam_cfg_master_chk.sv
module cam_cfg_master_chk (
  input logic clk,
  input logic rst,
  input logic scl,
  input logic sdaLow,
  input logic busy,
  input logic cfgDone,
  input logic rdValid
);

  // R8: once configured, stays configured
  p_done_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    cfgDone |=> cfgDone);

  // R8: busy for the whole of configuration
  p_busy_until_done_r8: assert property (@(posedge clk) disable iff (rst)
    !cfgDone |-> busy);

  // R9: clock line only low inside a transaction
  p_scl_low_busy_r9: assert property (@(posedge clk) disable iff (rst)
    !scl |-> busy);

  // R9: idle bus is released
  p_idle_released_r9: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (scl && !sdaLow));

  // R11: single-cycle strobe
  p_rdv_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    rdValid |=> !rdValid);

  // R11: strobe coincides with return to idle after configuration
  p_rdv_idle_r11: assert property (@(posedge clk) disable iff (rst)
    rdValid |-> (cfgDone && !busy));

endmodule

bind cam_cfg_master cam_cfg_master_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .scl     (scl),
  .sdaLow  (sdaLow),
  .busy    (busy),
  .cfgDone (cfgDone),
  .rdValid (rdValid)
);

// File: tb/cam_cfg_master_bench.sv
`timescale 1ns/1ps
module cam_cfg_master_bench;

  localparam int CLK_HZ   = 400;
  localparam int SCL_HZ   = 100;
  localparam int DELAY    = 100;
  localparam int HIGH_CYC = CLK_HZ / (2 * SCL_HZ);

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reqValid = 1'b0;
  logic       reqWrite = 1'b0;
  logic [7:0] reqAddr = 8'h00;
  logic [7:0] reqData = 8'h00;
  logic       rdValid;
  logic [7:0] rdData;
  logic       busy;
  logic       cfgDone;
  logic       scl;
  logic       sdaLow;
  logic       slaveLow = 1'b0;
  wire        sdaBus = ~(sdaLow | slaveLow);

  always #2.5 clk = ~clk;

  cam_cfg_master #(.CLK_HZ(CLK_HZ), .SCL_HZ(SCL_HZ), .DELAY_CYCLES(DELAY)) u_cam_cfg_master (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqData(reqData), .rdValid(rdValid), .rdData(rdData),
    .busy(busy), .cfgDone(cfgDone), .scl(scl), .sdaLow(sdaLow), .sdaIn(sdaBus)
  );

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // ---------------- sensor bus model ----------------
  logic [7:0] sensorRegs [0:255];
  logic [7:0] logA [0:511];
  logic [7:0] logD [0:511];
  int logN = 0;
  int startCnt = 0, stopCnt = 0;
  int startCyc [0:15];
  int stopCyc  [0:15];
  int cyc = 0;
  int ackFail = 0, badId = 0, sclHighFail = 0, sclHighCnt = 0, idleLowFail = 0;
  bit prevScl = 1, prevSda = 1, riseValid = 0;
  int riseCyc = 0;
  int bitCnt = 0, byteNo = 0, rdBit = 0, rdSeen = 0;
  bit rdMode = 0, lastNack = 0;
  logic [7:0] sh = 0, regPtr = 0, rdOut = 0;

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (!scl && !busy) idleLowFail++;
      if (prevScl && scl && prevSda && !sdaBus) begin
        if (startCnt < 16) startCyc[startCnt] = cyc;
        startCnt++;
        bitCnt = 0; byteNo = 0; rdMode = 0; slaveLow = 0; riseValid = 0;
      end else if (prevScl && scl && !prevSda && sdaBus) begin
        if (stopCnt < 16) stopCyc[stopCnt] = cyc;
        stopCnt++;
      end else if (!prevScl && scl) begin
        riseCyc = cyc; riseValid = 1;
        if (rdMode) begin
          rdSeen++;
          if (rdSeen == 9) lastNack = sdaBus;
        end else if (bitCnt == 8) begin
          if (!sdaBus) ackFail++;
          if (byteNo == 0) begin
            if (sh == 8'h43) begin
              rdMode = 1; rdBit = 0; rdSeen = 0; rdOut = sensorRegs[regPtr];
            end else if (sh != 8'h42) badId++;
          end else if (byteNo == 1) begin
            regPtr = sh;
          end else if (byteNo == 2) begin
            sensorRegs[regPtr] = sh;
            if (logN < 512) begin logA[logN] = regPtr; logD[logN] = sh; end
            logN++;
          end
          byteNo++;
          bitCnt = 0;
        end else begin
          sh = {sh[6:0], sdaBus};
          bitCnt++;
        end
      end else if (prevScl && !scl) begin
        if (riseValid) begin
          sclHighCnt++;
          if (cyc - riseCyc != HIGH_CYC) sclHighFail++;
        end
        riseValid = 0;
        if (rdMode && rdBit < 8) begin
          slaveLow = !rdOut[7 - rdBit];
          rdBit++;
        end else begin
          slaveLow = 0;
        end
      end
    end
    prevScl = scl;
    prevSda = sdaBus;
  end

  // ---------------- host helper ----------------
  task automatic hostOp(input bit wr, input logic [7:0] a, input logic [7:0] d,
                        output logic [7:0] got, output int strobes);
    @(negedge clk);
    while (busy) @(negedge clk);
    reqValid = 1; reqWrite = wr; reqAddr = a; reqData = d;
    @(negedge clk);
    reqValid = 0;
    got = 8'h00; strobes = 0;
    do begin
      @(negedge clk);
      if (rdValid) begin got = rdData; strobes++; end
    end while (busy);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [7:0] got;
    int strobes, s0, p0, n0;
    logic [7:0] expA [0:5];
    logic [7:0] expD [0:5];
    bit seen77;
    expA = '{8'h12, 8'h12, 8'h40, 8'h8C, 8'h3A, 8'h11};
    expD = '{8'h80, 8'h04, 8'hD0, 8'h00, 8'h04, 8'h01};
    for (int i = 0; i < 256; i++) sensorRegs[i] = 8'h00;

    repeat (5) @(negedge clk);
    // R1 reset state
    check(scl == 1'b1,     "R1 scl", scl, 1);
    check(sdaLow == 1'b0,  "R1 sdaLow", sdaLow, 0);
    check(cfgDone == 1'b0, "R1 cfgDone", cfgDone, 0);
    check(busy == 1'b1,    "R1 busy", busy, 1);
    check(rdValid == 1'b0, "R1 rdValid", rdValid, 0);
    rst = 0;

    // R10: request during configuration is dropped
    repeat (20) @(negedge clk);
    reqValid = 1; reqWrite = 1; reqAddr = 8'h77; reqData = 8'h99;
    @(negedge clk);
    reqValid = 0;

    while (!cfgDone) @(negedge clk);
    // R8: done only after all table writes finished
    check(stopCnt == 6, "R8 stops before done", stopCnt, 6);
    check(busy == 1'b0, "R8 idle at done", busy, 0);
    // R2 table contents and order
    check(logN == 6, "R2 write count", logN, 6);
    for (int i = 0; i < 6; i++) begin
      check(logA[i] == expA[i], "R2 register", logA[i], expA[i]);
      check(logD[i] == expD[i], "R2 value", logD[i], expD[i]);
    end
    check(sensorRegs[8'h12] == 8'h04 && sensorRegs[8'h40] == 8'hD0, "R2 rgb565",
          {sensorRegs[8'h12], sensorRegs[8'h40]}, 16'h04D0);
    // R3 pause placement
    check(startCyc[1] - stopCyc[0] >= DELAY, "R3 pause gap", startCyc[1] - stopCyc[0], DELAY);
    check(startCyc[2] - stopCyc[1] < DELAY, "R3 no pause", startCyc[2] - stopCyc[1], DELAY);
    // R6 framing during configuration
    check(startCnt == 6, "R6 init starts", startCnt, 6);
    seen77 = 0;
    for (int i = 0; i < logN && i < 512; i++) if (logA[i] == 8'h77) seen77 = 1;
    check(!seen77, "R10 dropped during init", seen77, 0);

    // R4 write sweep
    for (int i = 0; i < 64; i++) begin
      logic [7:0] a, d;
      a = 8'(8'h80 + i);
      d = 8'((i * 29 + 5) & 255);
      s0 = startCnt; p0 = stopCnt; n0 = logN;
      hostOp(1, a, d, got, strobes);
      check(logN == n0 + 1 && logA[n0] == a && logD[n0] == d, "R4 write", {logA[n0], logD[n0]}, {a, d});
      check(startCnt - s0 == 1 && stopCnt - p0 == 1, "R6 write framing", startCnt - s0, 1);
      check(strobes == 0, "R11 no strobe on write", strobes, 0);
    end
    check(ackFail == 0, "R4 ninth clock released", ackFail, 0);
    check(badId == 0, "R4 device id", badId, 0);

    // R10: second request right after acceptance
    @(negedge clk);
    while (busy) @(negedge clk);
    n0 = logN;
    reqValid = 1; reqWrite = 1; reqAddr = 8'h21; reqData = 8'h3C;
    @(negedge clk);
    reqAddr = 8'h22; reqData = 8'hC3;
    check(busy == 1'b1, "R9 busy after accept", busy, 1);
    @(negedge clk);
    reqValid = 0;
    while (busy) @(negedge clk);
    check(logN == n0 + 1, "R10 busy request dropped", logN - n0, 1);
    check(logA[n0] == 8'h21 && logD[n0] == 8'h3C, "R10 first kept", {logA[n0], logD[n0]}, 16'h213C);

    // R5 read sweep over all registers
    for (int i = 0; i < 256; i++) sensorRegs[i] = 8'((i * 37 + 11) & 255);
    for (int i = 0; i < 256; i++) begin
      logic [7:0] e;
      e = 8'((i * 37 + 11) & 255);
      s0 = startCnt; p0 = stopCnt; lastNack = 0;
      hostOp(0, 8'(i), 8'h00, got, strobes);
      check(got == e, "R5 read data", got, e);
      check(strobes == 1, "R11 one strobe", strobes, 1);
      if (i < 16) begin
        check(lastNack == 1'b1, "R5 nack", lastNack, 1);
        check(startCnt - s0 == 2 && stopCnt - p0 == 2, "R6 read framing", startCnt - s0, 2);
      end
    end
    check(badId == 0, "R5 device id", badId, 0);

    // R7 and R9 bus timing summaries
    check(sclHighCnt > 0 && sclHighFail == 0, "R7 scl high time", sclHighFail, 0);
    check(idleLowFail == 0, "R9 scl low while idle", idleLowFail, 0);
    check(cfgDone == 1'b1, "R8 done stays", cfgDone, 1);

    finishRun();
  end

endmodule